// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block derives a processor clock and a peripheral clock from a reference signal. The reference is chosen by a static strap. With the strap low, the oscillator input is the reference. With the strap high, the external frequency input is the reference. The processor clock completes one period every three reference cycles and is high for one of those three. The peripheral clock toggles on every rising edge of the processor clock. It therefore runs at half the processor rate with equal high and low times. The oscillator input is also passed straight through to an output.

A counter-sync input holds the divider in a known idle state while it is high. Several instances that release sync on the same reference cycle then produce clocks in phase. Everything is modelled in one sampling clock domain, `clk`. A reference cycle is counted at each rising transition of the selected reference level, as seen by `clk`. The reference must therefore change no faster than every second `clk` cycle.

Top module: `proc_clock_gen`

## Requirements
- R1: With sync low, the processor clock rises once every three reference rising edges.
- R2: The processor clock is high for exactly one reference cycle out of three. It goes high after the reference edge that completes a period and low after the next reference edge.
- R3: The peripheral clock changes only when the processor clock rises or when the divider is cleared. On each processor clock rise it inverts, so it is high for three reference cycles and low for three.
- R4: With `selExt` = 0 only `oscIn` edges advance the divider. With `selExt` = 1 only `extIn` edges do. Edges on the unselected input leave both clocks unchanged.
- R5: While `syncIn` is 1, both clocks are 0 from the next `clk` edge, and reference edges do not advance the divider. `rstN` = 0 has the same effect.
- R6: After `syncIn` returns to 0, the first reference edge raises the processor clock and drives the peripheral clock to 1.
- R7: `oscOut` equals `oscIn` at all times, with no register in the path.
- R8: A reference edge is a 0-to-1 change of the selected input between two `clk` edges. Both clocks update at the `clk` edge that first samples the new 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all state |
| rstN | input | 1 | Active-low synchronous reset, clears the divider |
| oscIn | input | 1 | Oscillator reference level |
| extIn | input | 1 | External frequency reference level |
| selExt | input | 1 | Source strap: 0 selects oscIn, 1 selects extIn |
| syncIn | input | 1 | High holds the divider cleared |
| procClk | output | 1 | Processor clock, one third of the reference rate |
| perClk | output | 1 | Peripheral clock, half the processor clock rate |
| oscOut | output | 1 | Unregistered copy of oscIn |

## Verification
Both divided clocks are registered, so each result is due at the first `clk` rising edge that samples a new reference high level. The same holds for a sync assertion. The bench drives every input at a falling edge of `clk` and reads the outputs at the following falling edge, half a cycle after the update. The pass-through output has no register, so it is read at the same falling edge that changes `oscIn`. The expected clock levels come from the reference edge count since sync was released: the processor clock is high when the count modulo 3 is 1, and the peripheral clock is high when the integer part of (count-1)/3 is even.

// File: rtl/clkdiv3_pkg.sv
package clkdiv3_pkg;
  // Strobes from the divide control to the clock datapath
  typedef struct packed {
    logic clear;     // hold outputs in idle
    logic advance;   // a reference edge was counted
    logic wrapZero;  // counter enters its high state on this edge
  } divStrobes_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import clkdiv3_pkg::*;
#(
  parameter int DIV_RATIO = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refLevel,
  input  logic        syncIn,
  output divStrobes_t strobes
);
  localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic             prevRef;
  logic             refEdge;
  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) prevRef <= 1'b0;
    else       prevRef <= refLevel;
  end

  assign refEdge = refLevel & ~prevRef;

  // Idle state is the last count, so the first edge lands on zero
  always_ff @(posedge clk) begin
    if (!rstN || syncIn)
      phaseCnt <= LAST;
    else if (refEdge)
      phaseCnt <= (phaseCnt == LAST) ? '0 : phaseCnt + 1'b1;
  end

  always_comb begin
    strobes.clear    = syncIn;
    strobes.advance  = refEdge & ~syncIn;
    strobes.wrapZero = refEdge & ~syncIn & (phaseCnt == LAST);
  end
endmodule

// File: rtl/div_path.sv
module div_path
  import clkdiv3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  divStrobes_t strobes,
  output logic        procClk,
  output logic        perClk
);
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      procClk <= 1'b0;
      perClk  <= 1'b0;
    end else if (strobes.wrapZero) begin
      procClk <= 1'b1;
      perClk  <= ~perClk;
    end else if (strobes.advance) begin
      procClk <= 1'b0;
    end
  end
endmodule

// File: rtl/proc_clock_gen.sv
module proc_clock_gen
  import clkdiv3_pkg::*;
#(
  parameter int DIV_RATIO = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscIn,
  input  logic extIn,
  input  logic selExt,
  input  logic syncIn,
  output logic procClk,
  output logic perClk,
  output logic oscOut
);
  logic        refLevel;
  divStrobes_t strobes;

  assign refLevel = selExt ? extIn : oscIn;
  assign oscOut   = oscIn;

  div_ctrl #(.DIV_RATIO(DIV_RATIO)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refLevel (refLevel),
    .syncIn   (syncIn),
    .strobes  (strobes)
  );

  div_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .procClk (procClk),
    .perClk  (perClk)
  );
endmodule

// File: rtl/proc_clock_gen_chk.sv
module proc_clock_gen_chk (
  input logic clk,
  input logic rstN,
  input logic oscIn,
  input logic extIn,
  input logic selExt,
  input logic syncIn,
  input logic procClk,
  input logic perClk,
  input logic oscOut
);
  logic prevSel;
  logic selEdge;

  always_ff @(posedge clk) begin
    if (!rstN) prevSel <= 1'b0;
    else       prevSel <= selExt ? extIn : oscIn;
  end
  assign selEdge = (selExt ? extIn : oscIn) & ~prevSel;

  // R5: sync forces both clocks low on the next edge
  a_r5_sync_clears: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (!procClk && !perClk));

  // R2: a high processor clock falls after the next counted edge
  a_r2_high_one_ref: assert property (@(posedge clk) disable iff (!rstN)
    (procClk && selEdge && !syncIn) |=> !procClk);

  // R3: peripheral clock moves only on a processor rise or a clear
  a_r3_per_moves_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(perClk) |-> ($rose(procClk) || $past(syncIn)));

  // R7: oscillator copy is exact
  a_r7_osc_copy: assert property (@(posedge clk) disable iff (!rstN)
    oscOut == oscIn);
endmodule

bind proc_clock_gen proc_clock_gen_chk u_chk (.*);

// File: tb/sim_proc_clock_gen.sv
`timescale 1ns/1ps
module sim_proc_clock_gen;
  logic clk = 1'b0;
  logic rstN, oscIn, extIn, selExt, syncIn;
  logic procClk, perClk, oscOut;
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  proc_clock_gen u0 (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .extIn(extIn),
    .selExt(selExt), .syncIn(syncIn),
    .procClk(procClk), .perClk(perClk), .oscOut(oscOut)
  );

  task automatic check(input string req, input string what,
                       input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // One reference cycle on the chosen line; outputs read half a cycle
  // after the clk edge that samples the new high level
  task automatic tick_ref(input bit useExt, output logic pc, output logic pe);
    @(negedge clk);
    if (useExt) extIn = 1'b1; else oscIn = 1'b1;
    @(negedge clk);
    pc = procClk;
    pe = perClk;
    if (useExt) extIn = 1'b0; else oscIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_sync(input logic v);
    @(negedge clk);
    syncIn = v;
    @(negedge clk);
  endtask

  // Run n edges after release and compare with the ideal waveform
  task automatic run_pattern(input bit useExt, input int n, input string req);
    logic pc, pe;
    for (int k = 1; k <= n; k++) begin
      tick_ref(useExt, pc, pe);
      check(req, $sformatf("procClk edge %0d", k), pc, (k % 3) == 1);
      check(req, $sformatf("perClk edge %0d", k), pe, (((k - 1) / 3) % 2) == 0);
    end
  endtask

  task automatic test_reset();
    check("R5", "procClk in reset", procClk, 1'b0);
    check("R5", "perClk in reset", perClk, 1'b0);
  endtask

  task automatic test_osc_divide();
    selExt = 1'b0;
    set_sync(1'b0);
    run_pattern(1'b0, 12, "R1 R2 R3 R8");
  endtask

  task automatic test_ext_select();
    logic pc, pe;
    set_sync(1'b1);
    selExt = 1'b1;
    check("R5", "procClk under sync", procClk, 1'b0);
    check("R5", "perClk under sync", perClk, 1'b0);
    set_sync(1'b0);
    run_pattern(1'b1, 4, "R4 ext source");
    // state after 4 edges: procClk=1, perClk=0; osc edges must not move it
    for (int k = 0; k < 4; k++) begin
      tick_ref(1'b0, pc, pe);
      check("R4", "procClk with osc unselected", pc, 1'b1);
      check("R4", "perClk with osc unselected", pe, 1'b0);
    end
  endtask

  task automatic test_sync_midrun();
    logic pc, pe;
    set_sync(1'b1);
    selExt = 1'b0;
    set_sync(1'b0);
    tick_ref(1'b0, pc, pe);
    tick_ref(1'b0, pc, pe);
    set_sync(1'b1);
    check("R5", "procClk after sync", procClk, 1'b0);
    check("R5", "perClk after sync", perClk, 1'b0);
    for (int k = 0; k < 4; k++) begin
      tick_ref(1'b0, pc, pe);
      check("R5", "procClk held by sync", pc, 1'b0);
      check("R5", "perClk held by sync", pe, 1'b0);
    end
    set_sync(1'b0);
    tick_ref(1'b0, pc, pe);
    check("R6", "procClk first edge", pc, 1'b1);
    check("R6", "perClk first edge", pe, 1'b1);
    tick_ref(1'b0, pc, pe);
    check("R2", "procClk second edge", pc, 1'b0);
  endtask

  task automatic test_osc_copy();
    @(negedge clk);
    oscIn = 1'b1;
    #1 check("R7", "oscOut high", oscOut, 1'b1);
    oscIn = 1'b0;
    #1 check("R7", "oscOut low", oscOut, 1'b0);
    set_sync(1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R8 watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    rstN = 1'b0; oscIn = 1'b0; extIn = 1'b0; selExt = 1'b0; syncIn = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_osc_divide();
    test_ext_select();
    test_sync_midrun();
    test_osc_copy();
    done = 1'b1;
    finish_run();
  end
endmodule